// File: doc/BRIEF.md
# Frame Sync Period Checker and Frame Aligner

The block receives a reference clock and an 8 kHz frame sync pulse derived from that same clock. On each rising sync edge it measures how many reference cycles have elapsed since the previous edge. It declares the sync trustworthy only when that count equals a fixed nominal period exactly. The nominal period is a parameter with a default of 1024, which is the 8.192 MHz / 8 kHz case.

While the sync is trusted, each qualifying edge pulls a local frame-phase counter back to zero. As a result, the regenerated frame pulse starts on the first reference clock edge that follows the sync rise. Between such edges, and whenever the sync is untrusted, the counter runs freely with the nominal period. A select input inverts the sync internally, so an active-low frame pulse can be fed in directly.

Top module: `fsync_align`

## Requirements
- R1: While reset is held and on the first cycle after it, `valid` is 0, `frame_phase` is 0 and `frame_pulse` is 1.
- R2: The first sync edge after reset, or after a timeout, only starts the measurement. `valid` goes to 1 on the clock edge that samples a sync edge exactly NOMINAL cycles after the previous sync edge.
- R3: A sync edge that arrives after fewer than NOMINAL cycles, or after more, clears `valid` on the clock edge that samples it. Measurement restarts from that edge.
- R4: If NOMINAL cycles pass after a sync edge without a new one, `valid` is cleared on that cycle, before any further edge arrives.
- R5: A sync edge that completes a period of exactly NOMINAL cycles loads `frame_phase` with 0 on the clock edge that samples it. That is the first reference edge lagging the sync rise, and `frame_pulse` is high in the cycle that follows.
- R6: In the absence of a qualifying edge, `frame_phase` counts 0, 1, …, NOMINAL-1 and wraps back to 0.
- R7: With `sync_active_low` = 1, a falling transition of `sync_in` is the frame edge. With 0, a rising transition is.
- R8: A sync edge that does not complete an exact NOMINAL period has no effect on `frame_phase`. The counter continues its free-running sequence.
- R9: `frame_pulse` is 1 exactly in the cycles where `frame_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame sync, synchronous to clk |
| sync_active_low | input | 1 | 1: the sync is active low and is inverted internally |
| valid | output | 1 | Sync period verified against NOMINAL |
| frame_pulse | output | 1 | One-cycle pulse at frame phase 0 |
| frame_phase | output | $clog2(NOMINAL) | Cycle index within the output frame |

## Verification
The hardest case to reach from the ports is a sync edge that lands while the free-running counter is out of phase with the sync. The block must then re-align only if that edge closes an exact period. The stimulus first builds a trusted run. It then inserts a short period, which both drops `valid` and shifts the sync phase, and follows it with edges spaced exactly at the nominal period so that a true re-alignment happens at a phase other than zero. Timeout is reached by holding the sync idle for longer than one period, and polarity by replaying a train with the inverted sense.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // True when an elapsed-cycle count marks the end of an exact nominal period
  function automatic bit period_done(input int unsigned elapsed, input int unsigned nominal);
    return elapsed == nominal - 1;
  endfunction

  // Free-running frame phase step with wrap at the nominal period
  function automatic int unsigned phase_step(input int unsigned ph, input int unsigned nominal);
    return (ph == nominal - 1) ? 0 : ph + 1;
  endfunction
endpackage

// File: rtl/fsync_edge.sv
module fsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic invert,
  output logic rise
);
  logic s_now;
  logic s_prev;

  assign s_now = sync_in ^ invert;

  always_ff @(posedge clk) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= s_now;
  end

  assign rise = s_now & ~s_prev;
endmodule

// File: rtl/fsync_period.sv
module fsync_period
  import fsync_pkg::*;
#(
  parameter int unsigned NOMINAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic good_edge,
  output logic timeout,
  output logic valid
);
  localparam int unsigned CW = $clog2(NOMINAL + 1);
  localparam logic [CW-1:0] SAT = CW'(NOMINAL);

  logic [CW-1:0] elapsed;
  logic          seen;
  logic          at_end;

  assign at_end    = period_done(32'(elapsed), NOMINAL);
  assign good_edge = rise & seen & at_end;
  assign timeout   = ~rise & seen & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      seen    <= 1'b0;
      valid   <= 1'b0;
    end else if (rise) begin
      elapsed <= '0;
      seen    <= 1'b1;
      valid   <= good_edge;
    end else begin
      if (elapsed != SAT) elapsed <= elapsed + 1'b1;
      if (timeout) valid <= 1'b0;
    end
  end

  a_r2_rise_needs_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(good_edge));
  a_r3_bad_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !good_edge) |=> !valid);
  a_r4_no_overlong_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (elapsed < SAT));
endmodule

// File: rtl/fsync_framer.sv
module fsync_framer
  import fsync_pkg::*;
#(
  parameter int unsigned NOMINAL = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       align,
  output logic [$clog2(NOMINAL)-1:0] phase,
  output logic                       pulse
);
  localparam int unsigned PW = $clog2(NOMINAL);

  always_ff @(posedge clk) begin
    if (!rst_n)     phase <= '0;
    else if (align) phase <= '0;
    else            phase <= PW'(phase_step(32'(phase), NOMINAL));
  end

  assign pulse = (phase == '0);

  a_r5_align_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(align) |-> (phase == '0));
  a_r6_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!align && phase == PW'(NOMINAL - 1)) |=> (phase == '0));
  a_r6_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!align && phase != PW'(NOMINAL - 1)) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/fsync_align.sv
module fsync_align #(
  parameter int unsigned NOMINAL = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sync_in,
  input  logic                       sync_active_low,
  output logic                       valid,
  output logic                       frame_pulse,
  output logic [$clog2(NOMINAL)-1:0] frame_phase
);
  logic rise;
  logic good_edge;
  logic timeout;

  fsync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .invert  (sync_active_low),
    .rise    (rise)
  );

  fsync_period #(.NOMINAL(NOMINAL)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .good_edge (good_edge),
    .timeout   (timeout),
    .valid     (valid)
  );

  fsync_framer #(.NOMINAL(NOMINAL)) u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .align (good_edge),
    .phase (frame_phase),
    .pulse (frame_pulse)
  );

  a_r4_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !valid);
  a_r8_off_period_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !good_edge && frame_phase == 2'd1) |=> (frame_phase == 2'd2));
endmodule

// File: tb/tb_fsync_align.sv
module tb_fsync_align;
  localparam int NOM = 16;
  localparam int PW = $clog2(NOM);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic sync_active_low = 1'b0;
  logic valid;
  logic frame_pulse;
  logic [PW-1:0] frame_phase;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int  m_prev = 0, m_since = 0, m_phase = 0;
  bit  m_seen = 0, m_valid = 0;

  always #(TCLK/2) clk = ~clk;

  fsync_align #(.NOMINAL(NOM)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_active_low(sync_active_low),
    .valid(valid), .frame_pulse(frame_pulse), .frame_phase(frame_phase)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic tick(input bit s_in, input bit pol, input string tag);
    int s;
    bit edge_seen, good;
    sync_in = s_in;
    sync_active_low = pol;
    s = (s_in ^ pol) ? 1 : 0;
    edge_seen = (s == 1) && (m_prev == 0);
    good = edge_seen && m_seen && (m_since + 1 == NOM);
    if (edge_seen) begin
      m_valid = good;
      m_since = 0;
      m_seen = 1;
    end else begin
      if (m_seen && m_since + 1 == NOM) m_valid = 0;
      if (m_since < NOM) m_since++;
    end
    if (good) m_phase = 0;
    else      m_phase = (m_phase + 1) % NOM;
    m_prev = s;
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(valid), int'(m_valid), "valid");
    check(tag, int'(frame_phase), m_phase, "frame_phase");
    check("R9", int'(frame_pulse), (m_phase == 0) ? 1 : 0, "frame_pulse");
  endtask

  // pulses of given width, one every per cycles, repeated n times
  task automatic train(input int per, input int n, input int width, input bit pol, input string tag);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < per; k++)
        tick(((k < width) ? 1'b1 : 1'b0) ^ pol, pol, tag);
  endtask

  task automatic idle(input int n, input bit pol, input string tag);
    for (int i = 0; i < n; i++) tick(pol, pol, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(valid), 0, "valid in reset");
    check("R1", int'(frame_phase), 0, "frame_phase in reset");
    check("R1", int'(frame_pulse), 1, "frame_pulse in reset");
    rst_n = 1'b1;
    tick(1'b0, 1'b0, "R1");
    check("R1", int'(valid), 0, "valid after reset");

    idle(5, 1'b0, "R6");             // free run, phase offset from sync
    train(NOM, 4, 3, 1'b0, "R2");    // first edge starts, second validates
    check("R2", int'(valid), 1, "valid after exact periods");
    train(NOM - 4, 1, 2, 1'b0, "R3");// short period then re-sync
    train(NOM, 3, 1, 1'b0, "R5");
    train(NOM + 3, 2, 2, 1'b0, "R3");// long periods
    train(NOM, 3, 2, 1'b0, "R8");
    train(7, 3, 1, 1'b0, "R8");      // off-period edges never re-align
    train(NOM, 3, 4, 1'b0, "R2");
    idle(NOM + 5, 1'b0, "R4");       // timeout without a further edge
    check("R4", int'(valid), 0, "valid after timeout");
    train(NOM, 4, 3, 1'b1, "R7");    // active-low sync
    check("R7", int'(valid), 1, "valid with inverted sync");
    idle(2 * NOM + 3, 1'b1, "R6");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule